// File: doc/BRIEF.md
# USB Device State and Configuration Tracker

This block keeps the standard USB device state (default, addressed, configured) for a device controller in which firmware decodes the configuration requests, not hardware. The block does not parse packets. A protocol front end gives it strobes for a bus reset, a completed set-address (with the new address value), the arrival of a SETUP packet, and a host attempt at the status stage. The CPU register interface gives it command strobes that move the device into or out of the configured state, that release the status stage, and that reject the current request with STALL. The CPU also writes a self-powered flag, which is reported back to the host.

A control request opens when its SETUP packet arrives. Until firmware issues a command for that request, each status-stage attempt is answered with NAK. Firmware commands therefore always come before the status stage completes. The configured and addressed transitions happen only on these explicit commands inside an open, non-stalled request. Every state change raises a sticky interrupt, which the CPU acknowledges through a clear strobe.

Top module: `usbdev_state_track`

## Requirements
- R1: After synchronous reset, the outputs are: dev_state_o = 0 (default), irq_o = 0, self_pwr_o = 0, ep0_stall_o = 0 and status_rsp_o = 0. Every output is registered and changes on the clock edge that samples its cause. dev_state_o codes are 0 default, 1 addressed, 2 configured. The value 3 never appears.
- R2: bus_reset_i returns dev_state_o to 0 from any state and sets irq_o. It also closes any open request, clears ep0_stall_o, and produces status_rsp_o = 0 in that cycle.
- R3: A set_addr_stb_i with a nonzero set_addr_i in state 0 moves the state to 1 and sets irq_o. A zero address in state 1 or 2 moves the state to 0 and sets irq_o. Any other set-address leaves both the state and irq_o unchanged.
- R4: An accepted cfg_set_i in state 1 or 2 moves the state to 2 and sets irq_o.
- R5: An accepted cfg_clr_i in state 1 or 2 moves the state to 1 and sets irq_o. If cfg_set_i and cfg_clr_i are accepted in the same cycle, the clear wins.
- R6: cfg_set_i and cfg_clr_i in state 0 are ignored. The state, irq_o and the status-stage release are all unchanged.
- R7: A command (cfg_set_i, cfg_clr_i, req_done_i or stall_cmd_i) is accepted only when a request is open and not stalled, and when neither setup_stb_i nor bus_reset_i is high in the same cycle. Otherwise it has no effect.
- R8: An accepted stall_cmd_i sets ep0_stall_o. The flag holds until the next setup_stb_i or bus_reset_i.
- R9: status_req_i produces a one-cycle status_rsp_o on the next edge. The value is 0 when no request is open, 3 (STALL) when the request is stalled, 2 (NAK) when it has not yet been released, and 1 (ACK) when it has been released. ACK closes the request. NAK keeps it open. A release in the same cycle as status_req_i takes effect only for later attempts.
- R10: A request is released by an accepted cfg_set_i or cfg_clr_i that changes or confirms the state, or by an accepted req_done_i. req_done_i leaves the state unchanged.
- R11: irq_o stays high until irq_clr_i. If a state-change event and irq_clr_i occur in the same cycle, irq_o is left high.
- R12: self_pwr_we_i loads self_pwr_i into self_pwr_o at any time. A bus reset does not change self_pwr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset detected |
| set_addr_stb_i | input | 1 | Set-address took effect |
| set_addr_i | input | ADDR_W | New device address |
| setup_stb_i | input | 1 | SETUP packet received, opens a request |
| status_req_i | input | 1 | Host attempts the status stage |
| cfg_set_i | input | 1 | CPU command: enter configured |
| cfg_clr_i | input | 1 | CPU command: leave configured |
| req_done_i | input | 1 | CPU command: release status stage only |
| stall_cmd_i | input | 1 | CPU command: reject request with STALL |
| self_pwr_we_i | input | 1 | Write strobe for the self-powered flag |
| self_pwr_i | input | 1 | Self-powered value to write |
| irq_clr_i | input | 1 | Clear the state-change interrupt |
| dev_state_o | output | 2 | Device state code |
| irq_o | output | 1 | State-change interrupt |
| self_pwr_o | output | 1 | Self-powered status for the host |
| ep0_stall_o | output | 1 | Endpoint 0 stall request |
| status_rsp_o | output | 2 | Status-stage answer pulse: 0 none, 1 ACK, 2 NAK, 3 STALL |

## Verification
The bench builds the block with ADDR_W = 3. This lets it sweep all eight addresses from each of the three states and cover every zero/nonzero set-address case. For each start state, with the request either open or closed, it drives all sixteen combinations of the set, clear, release and stall commands. It compares the resulting state, interrupt, stall flag and status-stage answer with values worked out from the requirements. Directed sequences then cover the same-cycle corners: a command arriving with a SETUP, a command after a stall, a release arriving with a status attempt, and an interrupt set arriving with its clear.

// File: rtl/usbdev_pkg.sv
package usbdev_pkg;

  typedef enum logic [1:0] {
    ST_DEFAULT = 2'd0,
    ST_ADDR    = 2'd1,
    ST_CONF    = 2'd2
  } dev_st_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } rsp_e;

endpackage

// File: rtl/usbdev_fsm.sv
module usbdev_fsm
  import usbdev_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_i,
  input  logic              addr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_set_ok_i,
  input  logic              cfg_clr_ok_i,
  output dev_st_e           state_o,
  output logic              change_o,
  output logic              taken_o
);

  dev_st_e st_q, st_d;
  logic    addr_nz;

  assign addr_nz = (addr_i != '0);

  // Priority: bus reset, then set-address, then CPU configuration commands.
  always_comb begin
    st_d     = st_q;
    change_o = 1'b0;
    taken_o  = 1'b0;
    if (bus_reset_i) begin
      st_d     = ST_DEFAULT;
      change_o = 1'b1;
    end else if (addr_stb_i) begin
      if (addr_nz) begin
        if (st_q == ST_DEFAULT) begin
          st_d     = ST_ADDR;
          change_o = 1'b1;
        end
      end else if (st_q != ST_DEFAULT) begin
        st_d     = ST_DEFAULT;
        change_o = 1'b1;
      end
    end else if ((st_q != ST_DEFAULT) && (cfg_set_ok_i || cfg_clr_ok_i)) begin
      taken_o  = 1'b1;
      change_o = 1'b1;
      st_d     = cfg_clr_ok_i ? ST_ADDR : ST_CONF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_DEFAULT;
    else     st_q <= st_d;
  end

  assign state_o = st_q;

  a_r2_bus_reset_default: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> (st_q == ST_DEFAULT));

  a_r6_default_holds: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_DEFAULT) && !addr_stb_i) |=> (st_q == ST_DEFAULT));

  a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
    (st_q != 2'd3));

endmodule

// File: rtl/usbdev_irq.sv
module usbdev_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  logic irq_q;

  // A new event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_q);

  a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_q);

endmodule

// File: rtl/usbdev_ctl_gate.sv
module usbdev_ctl_gate
  import usbdev_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic setup_i,
  input  logic status_i,
  input  logic stall_cmd_i,
  input  logic rel_i,
  input  logic taken_i,
  output logic accept_o,
  output logic stall_o,
  output rsp_e resp_o
);

  logic open_q, stall_q, rel_q;
  rsp_e resp_q;

  assign accept_o = open_q & ~stall_q & ~setup_i & ~bus_reset_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      stall_q <= 1'b0;
      rel_q   <= 1'b0;
      resp_q  <= RSP_NONE;
    end else if (bus_reset_i) begin
      open_q  <= 1'b0;
      stall_q <= 1'b0;
      rel_q   <= 1'b0;
      resp_q  <= RSP_NONE;
    end else if (setup_i) begin
      open_q  <= 1'b1;
      stall_q <= 1'b0;
      rel_q   <= 1'b0;
      resp_q  <= RSP_NONE;
    end else begin
      resp_q <= RSP_NONE;
      if (accept_o && stall_cmd_i)          stall_q <= 1'b1;
      if (accept_o && (rel_i || taken_i))   rel_q   <= 1'b1;
      if (status_i) begin
        if (!open_q)      resp_q <= RSP_NONE;
        else if (stall_q) resp_q <= RSP_STALL;
        else if (rel_q) begin
          resp_q <= RSP_ACK;
          open_q <= 1'b0;
          rel_q  <= 1'b0;
        end else          resp_q <= RSP_NAK;
      end
    end
  end

  assign stall_o = stall_q;
  assign resp_o  = resp_q;

  a_r9_ack_closes: assert property (@(posedge clk) disable iff (rst)
    (status_i && open_q && !stall_q && rel_q && !bus_reset_i && !setup_i)
      |=> ((resp_q == RSP_ACK) && !open_q));

  a_r8_stall_sticky: assert property (@(posedge clk) disable iff (rst)
    (stall_q && !setup_i && !bus_reset_i) |=> stall_q);

  a_r7_closed_rejects: assert property (@(posedge clk) disable iff (rst)
    !open_q |-> !accept_o);

endmodule

// File: rtl/usbdev_state_track.sv
module usbdev_state_track
  import usbdev_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_i,
  input  logic              set_addr_stb_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              setup_stb_i,
  input  logic              status_req_i,
  input  logic              cfg_set_i,
  input  logic              cfg_clr_i,
  input  logic              req_done_i,
  input  logic              stall_cmd_i,
  input  logic              self_pwr_we_i,
  input  logic              self_pwr_i,
  input  logic              irq_clr_i,
  output logic [1:0]        dev_state_o,
  output logic              irq_o,
  output logic              self_pwr_o,
  output logic              ep0_stall_o,
  output logic [1:0]        status_rsp_o
);

  logic    accept, taken, change;
  dev_st_e state;
  rsp_e    resp;
  logic    pwr_q;

  usbdev_ctl_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .bus_reset_i (bus_reset_i),
    .setup_i     (setup_stb_i),
    .status_i    (status_req_i),
    .stall_cmd_i (stall_cmd_i),
    .rel_i       (req_done_i),
    .taken_i     (taken),
    .accept_o    (accept),
    .stall_o     (ep0_stall_o),
    .resp_o      (resp)
  );

  usbdev_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .bus_reset_i  (bus_reset_i),
    .addr_stb_i   (set_addr_stb_i),
    .addr_i       (set_addr_i),
    .cfg_set_ok_i (accept & cfg_set_i),
    .cfg_clr_ok_i (accept & cfg_clr_i),
    .state_o      (state),
    .change_o     (change),
    .taken_o      (taken)
  );

  usbdev_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .set_i (change),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                pwr_q <= 1'b0;
    else if (self_pwr_we_i) pwr_q <= self_pwr_i;
  end

  assign self_pwr_o   = pwr_q;
  assign dev_state_o  = state;
  assign status_rsp_o = resp;

  a_r12_pwr_holds: assert property (@(posedge clk) disable iff (rst)
    !self_pwr_we_i |=> $stable(self_pwr_o));

endmodule

// File: tb/sim_usbdev_state_track.sv
`timescale 1ns/1ps
module sim_usbdev_state_track;

  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset_i = 0, set_addr_stb_i = 0, setup_stb_i = 0, status_req_i = 0;
  logic cfg_set_i = 0, cfg_clr_i = 0, req_done_i = 0, stall_cmd_i = 0;
  logic self_pwr_we_i = 0, self_pwr_i = 0, irq_clr_i = 0;
  logic [AW-1:0] set_addr_i = '0;
  logic [1:0] dev_state_o, status_rsp_o;
  logic irq_o, self_pwr_o, ep0_stall_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbdev_state_track #(.ADDR_W(AW)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    bus_reset_i = 0; set_addr_stb_i = 0; setup_stb_i = 0; status_req_i = 0;
    cfg_set_i = 0; cfg_clr_i = 0; req_done_i = 0; stall_cmd_i = 0;
    self_pwr_we_i = 0; irq_clr_i = 0;
  endtask

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bring the device to state s with no open request and irq cleared.
  task automatic go_state(int s);
    bus_reset_i = 1; tick();
    if (s >= 1) begin set_addr_stb_i = 1; set_addr_i = 3'd1; tick(); end
    if (s == 2) begin
      setup_stb_i = 1; tick();
      cfg_set_i = 1; tick();
      status_req_i = 1; tick();
      tick();
    end
    irq_clr_i = 1; tick();
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); rst = 0; tick();
    // R1 reset state
    chk(dev_state_o, 0, "R1 state");
    chk(irq_o, 0, "R1 irq");
    chk(self_pwr_o, 0, "R1 self_pwr");
    chk(ep0_stall_o, 0, "R1 stall");
    chk(status_rsp_o, 0, "R1 rsp");

    // R3 set-address sweep over all addresses from all states
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 8; a++) begin
        int es, ei;
        go_state(s);
        set_addr_stb_i = 1; set_addr_i = a[AW-1:0]; tick();
        if (a != 0) begin es = (s == 0) ? 1 : s; ei = (s == 0) ? 1 : 0; end
        else        begin es = 0;                ei = (s != 0) ? 1 : 0; end
        chk(dev_state_o, es, "R3 state");
        chk(irq_o, ei, "R3 irq");
      end
    end

    // R4 R5 R6 R7 R8 R9 R10: command sweep
    for (int s = 0; s < 3; s++) begin
      for (int op = 0; op < 2; op++) begin
        for (int c = 0; c < 16; c++) begin
          bit st, cl, rl, sk, taken, rel;
          int es, er;
          st = c[0]; cl = c[1]; rl = c[2]; sk = c[3];
          go_state(s);
          if (op == 1) begin setup_stb_i = 1; tick(); end
          cfg_set_i = st; cfg_clr_i = cl; req_done_i = rl; stall_cmd_i = sk;
          tick();
          taken = (op == 1) && (s != 0) && (st || cl);
          es = taken ? (cl ? 1 : 2) : s;
          rel = taken || ((op == 1) && rl);
          chk(dev_state_o, es, "R4 R5 R6 R7 state");
          chk(irq_o, taken, "R4 R5 R6 irq");
          chk(ep0_stall_o, (op == 1) && sk, "R8 stall");
          status_req_i = 1; tick();
          er = (op == 0) ? 0 : (sk ? 3 : (rel ? 1 : 2));
          chk(status_rsp_o, er, "R9 R10 rsp");
          tick();
          chk(status_rsp_o, 0, "R9 pulse");
        end
      end
    end

    // R7: command with setup in same cycle ignored
    go_state(1);
    setup_stb_i = 1; tick();
    setup_stb_i = 1; cfg_set_i = 1; tick();
    chk(dev_state_o, 1, "R7 setup same cycle");
    chk(irq_o, 0, "R7 irq");
    // R7 R8: command after stall ignored, stall holds, setup clears
    stall_cmd_i = 1; tick();
    cfg_set_i = 1; tick();
    chk(dev_state_o, 1, "R7 after stall");
    status_req_i = 1; tick();
    chk(status_rsp_o, 3, "R8 stall rsp");
    tick(); tick();
    chk(ep0_stall_o, 1, "R8 hold");
    setup_stb_i = 1; tick();
    chk(ep0_stall_o, 0, "R8 setup clears");

    // R9: release with status in the same cycle -> NAK, next -> ACK, then closed
    req_done_i = 1; status_req_i = 1; tick();
    chk(status_rsp_o, 2, "R9 same-cycle NAK");
    status_req_i = 1; tick();
    chk(status_rsp_o, 1, "R9 ACK");
    status_req_i = 1; tick();
    chk(status_rsp_o, 0, "R9 closed");
    chk(dev_state_o, 1, "R10 done keeps state");

    // R11: set and clear together keep irq, clear alone drops it
    setup_stb_i = 1; tick();
    cfg_set_i = 1; irq_clr_i = 1; tick();
    chk(irq_o, 1, "R11 set wins");
    tick(); tick();
    chk(irq_o, 1, "R11 sticky");
    irq_clr_i = 1; tick();
    chk(irq_o, 0, "R11 clear");

    // R2: bus reset from configured with stalled open request
    go_state(2);
    setup_stb_i = 1; tick();
    stall_cmd_i = 1; tick();
    bus_reset_i = 1; status_req_i = 1; tick();
    chk(dev_state_o, 0, "R2 state");
    chk(irq_o, 1, "R2 irq");
    chk(ep0_stall_o, 0, "R2 stall");
    chk(status_rsp_o, 0, "R2 rsp");
    status_req_i = 1; tick();
    chk(status_rsp_o, 0, "R2 closed");

    // R12: self-powered write and bus reset persistence
    self_pwr_we_i = 1; self_pwr_i = 1; tick();
    chk(self_pwr_o, 1, "R12 write");
    bus_reset_i = 1; tick();
    chk(self_pwr_o, 1, "R12 bus reset");
    self_pwr_i = 0; tick();
    chk(self_pwr_o, 1, "R12 no strobe");
    self_pwr_we_i = 1; self_pwr_i = 0; tick();
    chk(self_pwr_o, 0, "R12 clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule